// File: doc/BRIEF.md
# Two-Wire Register Slave for a Dual-String LED Brightness Controller

This block is the serial control front end of a two-channel LED current controller. A host on a two-wire bus (I2C-compatible, 7-bit addressing) writes and reads four 8-bit control registers. The block oversamples SCL and SDA on a fast system clock. It finds START, repeated START and STOP conditions and compares the address. It acknowledges each accepted byte and serves reads. The stored fields feed the analog side directly. These fields are the two sink enables, the unison select, a two-bit ramp-rate code, the display-supply mode and two 5-bit brightness codes. The sink enables and the second string's code come out already decoded for the selected mode.

One external pin has three roles, chosen by register. By default it is an active-low reset input: while it is held low, every register is cleared and writes have no effect. It can also be a logic input whose level can be read back, or an open-drain output.

The protocol engine has these states. IDLE is left on START and entered on STOP from any state. ADDR shifts in the address byte. It goes to ADDR_ACK on a match, or to WAIT on a mismatch, where the slave ignores the bus. ADDR_ACK goes to PTR for a write, or to RDATA for a read. PTR leads to PTR_ACK, and PTR_ACK leads to WDATA. WDATA commits the byte and goes to WDATA_ACK, which returns to WDATA for further bytes. RDATA shifts out a byte and goes to RACK. RACK returns to RDATA on a master ACK, or goes to WAIT on a NACK. A START in any state goes to ADDR.

Top module: `ledctl_i2c_regs`

## Requirements
- R1: The slave answers only the 7-bit address 0x36 (address byte 0x6C for write, 0x6D for read; bit 0 set means read). For any other address it never pulls SDA and no register changes.
- R2: For each accepted byte, the slave pulls SDA low from the falling SCL edge that ends bit 8 until the falling SCL edge that ends the ninth clock. SDA changes only while SCL is low.
- R3: A write is address byte, pointer byte, data byte. The data lands in the register selected by the pointer: 0x10 general, 0xA0 string-A brightness (bits 4:0), 0xB0 string-B brightness (bits 4:0), 0x80 pin control (bits 2:0). Registers change only through such a write or the pin reset.
- R4: Readback forces unused bits to 1: bits 7:6 of the general register, bits 7:5 of each brightness register and bits 7:3 of the pin register. After system reset the four registers read 0xC0, 0xE0, 0xE0 and 0xF8.
- R5: A write to any other pointer is acknowledged and discarded. A read from any other pointer returns 0xFF.
- R6: A read sends the register selected by the last pointer, MSB first, once per byte. A master ACK repeats the same register. A master NACK makes the slave release SDA and wait for STOP or START.
- R7: A repeated START restarts address reception in any state. A STOP returns to idle. A pointer byte followed by STOP or START writes nothing.
- R8: General register: bit0 string-A enable, bit1 string-B enable, bit2 unison, bit3 ramp_sel[0], bit4 ramp_sel[1], bit5 display-supply mode. sink_main_on equals bit0. sink_sub_on is 0 in display-supply mode; otherwise it equals bit0 in unison and bit1 if not. code_sub is the string-A code in unison and the string-B code otherwise.
- R9: Pin register: bit0=0 selects reset input. bit0=1 with bit1=0 selects logic input, and read bit 2 shows the pin level. bit0=1 with bit1=1 selects output, where pin_pull = 1 when bit2 = 0 and the pin is released when bit2 = 1. In the input and output modes a low pin resets nothing.
- R10: In reset mode with the pin low, all four registers are held at zero (all decoded outputs 0) and writes are acknowledged but ignored. After release, writes work again.
- R11: After system reset all decoded outputs are 0 and neither SDA nor the pin is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low system reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = pull SDA low |
| pin_in | input | 1 | Shared pin level |
| pin_pull | output | 1 | 1 = pull shared pin low |
| sink_main_on | output | 1 | String-A current sink enabled |
| sink_sub_on | output | 1 | String-B current sink enabled |
| unison | output | 1 | Both strings follow the string-A code |
| oled_mode | output | 1 | Second output used as voltage feedback |
| ramp_sel | output | 2 | Brightness ramp-rate select |
| code_main | output | 5 | String-A brightness code |
| code_sub | output | 5 | Effective string-B brightness code |

## Verification
The bench sends a wrong address and then a full pointer and data sequence. A slave that matched only part of the address, or kept listening after a mismatch, would ACK or overwrite the brightness. It breaks off a write with a repeated START between pointer and data. A slave that did not resynchronise would commit the next address byte as data. It reads the same register over several ACKed bytes and then NACKs, which catches a slave that shifts the wrong bit first or keeps driving SDA after the NACK. It also exercises the shared pin in all three modes. A design that decoded the modes wrongly would clear the registers from an input-mode low, or would miss the write lockout while the reset is held.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 5;
    localparam int GP_W   = 6;
    localparam int IO_W   = 3;

    localparam logic [BYTE_W-1:0] PTR_GP = 8'h10;
    localparam logic [BYTE_W-1:0] PTR_BA = 8'hA0;
    localparam logic [BYTE_W-1:0] PTR_BB = 8'hB0;
    localparam logic [BYTE_W-1:0] PTR_IO = 8'h80;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } slv_state_t;

    typedef struct packed {
        logic       oled;
        logic [1:0] ramp;
        logic       uni;
        logic       ens;
        logic       enm;
    } gp_t;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{INIT}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import ledctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h36,
    parameter int         WR_W     = GP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_pulse,
    output logic [BYTE_W-1:0] ptr,
    output logic [WR_W-1:0]   wr_data
);

    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    slv_state_t        state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic              rnw;
    logic              mack;
    logic              scl_d, sda_d;

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            tx       <= '0;
            rnw      <= 1'b0;
            mack     <= 1'b0;
            ptr      <= '0;
            wr_data  <= '0;
            wr_pulse <= 1'b0;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_d    <= scl_s;
            sda_d    <= sda_s;
            wr_pulse <= 1'b0;
            if (start_det) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_WAIT: begin
                    end
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                    rnw   <= shreg[0];
                                    state <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else if (state == ST_PTR) begin
                                ptr   <= shreg;
                                state <= ST_PTR_ACK;
                            end else begin
                                wr_data  <= shreg[WR_W-1:0];
                                wr_pulse <= 1'b1;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_rise) begin
                            cnt <= 4'd1;
                        end else if (scl_fall && cnt == 4'd1) begin
                            cnt <= '0;
                            if (state == ST_ADDR_ACK) begin
                                if (rnw) begin
                                    tx    <= rd_data;
                                    state <= ST_RDATA;
                                end else begin
                                    state <= ST_PTR;
                                end
                            end else begin
                                state <= ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            cnt   <= '0;
                            state <= ST_RACK;
                        end else if (scl_fall && cnt != 4'd0) begin
                            tx <= {tx[BYTE_W-2:0], 1'b1};
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                            cnt  <= 4'd1;
                        end else if (scl_fall && cnt == 4'd1) begin
                            cnt <= '0;
                            if (mack) begin
                                tx    <= rd_data;
                                state <= ST_RDATA;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_pull = 1'b1;
            ST_RDATA:                              sda_pull = ~tx[BYTE_W-1];
            default:                               sda_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/ledctl_regfile.sv
module ledctl_regfile
    import ledctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_s,
    input  logic              wr_pulse,
    input  logic [BYTE_W-1:0] ptr,
    input  logic [GP_W-1:0]   wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              hold,
    output gp_t               gp,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              pin_pull
);

    logic [IO_W-1:0] io_q;
    logic            in_mode;

    assign hold     = ~io_q[0] & ~pin_s;
    assign in_mode  = io_q[0] & ~io_q[1];
    assign pin_pull = io_q[0] & io_q[1] & ~io_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp     <= '0;
            code_a <= '0;
            code_b <= '0;
            io_q   <= '0;
        end else if (hold) begin
            gp     <= '0;
            code_a <= '0;
            code_b <= '0;
            io_q   <= '0;
        end else if (wr_pulse) begin
            case (ptr)
                PTR_GP:  gp     <= gp_t'(wr_data);
                PTR_BA:  code_a <= wr_data[CODE_W-1:0];
                PTR_BB:  code_b <= wr_data[CODE_W-1:0];
                PTR_IO:  io_q   <= wr_data[IO_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (ptr)
            PTR_GP:  rd_data = {{(BYTE_W-GP_W){1'b1}}, gp};
            PTR_BA:  rd_data = {{(BYTE_W-CODE_W){1'b1}}, code_a};
            PTR_BB:  rd_data = {{(BYTE_W-CODE_W){1'b1}}, code_b};
            PTR_IO:  rd_data = {{(BYTE_W-IO_W){1'b1}}, (in_mode ? pin_s : io_q[2]), io_q[1:0]};
            default: rd_data = '1;
        endcase
    end

endmodule

// File: rtl/ledctl_i2c_regs.sv
module ledctl_i2c_regs
    import ledctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h36,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              pin_in,
    output logic              pin_pull,
    output logic              sink_main_on,
    output logic              sink_sub_on,
    output logic              unison,
    output logic              oled_mode,
    output logic [1:0]        ramp_sel,
    output logic [CODE_W-1:0] code_main,
    output logic [CODE_W-1:0] code_sub
);

    logic              scl_s, sda_s, pin_s;
    logic              wr_pulse, hold;
    logic [BYTE_W-1:0] ptr, rd_data;
    logic [GP_W-1:0]   wr_data;
    gp_t               gp;
    logic [CODE_W-1:0] code_b;

    sync_chain #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    sync_chain #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));
    sync_chain #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

    i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .WR_W(GP_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .rd_data(rd_data), .sda_pull(sda_pull), .wr_pulse(wr_pulse),
        .ptr(ptr), .wr_data(wr_data));

    ledctl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .wr_pulse(wr_pulse),
        .ptr(ptr), .wr_data(wr_data), .rd_data(rd_data), .hold(hold),
        .gp(gp), .code_a(code_main), .code_b(code_b), .pin_pull(pin_pull));

    assign sink_main_on = gp.enm;
    assign sink_sub_on  = ~gp.oled & (gp.uni ? gp.enm : gp.ens);
    assign unison       = gp.uni;
    assign oled_mode    = gp.oled;
    assign ramp_sel     = gp.ramp;
    assign code_sub     = gp.uni ? code_main : code_b;

endmodule

// File: rtl/ledctl_i2c_regs_chk.sv
module ledctl_i2c_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_pull,
    input logic       hold,
    input logic       wr_pulse,
    input logic [4:0] code_main,
    input logic [4:0] code_sub,
    input logic [1:0] ramp_sel,
    input logic       sink_main_on,
    input logic       sink_sub_on,
    input logic       pin_pull
);

    AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s); // R2

    AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_s); // R2

    AST_NO_STRAY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pulse && !hold) |=> ($stable(code_main) && $stable(code_sub) &&
                                  $stable(ramp_sel) && $stable(sink_main_on) &&
                                  $stable(sink_sub_on))); // R3

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (code_main == 5'd0 && code_sub == 5'd0 && !sink_main_on &&
                  !sink_sub_on && !pin_pull)); // R10

endmodule

bind ledctl_i2c_regs ledctl_i2c_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
    .hold(hold), .wr_pulse(wr_pulse), .code_main(code_main),
    .code_sub(code_sub), .ramp_sel(ramp_sel), .sink_main_on(sink_main_on),
    .sink_sub_on(sink_sub_on), .pin_pull(pin_pull));

// File: tb/test_ledctl_i2c_regs.sv
`timescale 1ns/1ps
module test_ledctl_i2c_regs;

    localparam time TCK = 5ns;
    localparam time Q   = 40ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1, pin_drv = 1'b1;
    logic sda_line, pin_line;
    logic sda_pull, pin_pull, sink_main_on, sink_sub_on, unison, oled_mode;
    logic [1:0] ramp_sel;
    logic [4:0] code_main, code_sub;

    assign sda_line = sda_drv & ~sda_pull;
    assign pin_line = pin_drv & ~pin_pull;

    always #(TCK/2) clk = ~clk;

    ledctl_i2c_regs i_ledctl_i2c_regs (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
        .sda_pull(sda_pull), .pin_in(pin_line), .pin_pull(pin_pull),
        .sink_main_on(sink_main_on), .sink_sub_on(sink_sub_on),
        .unison(unison), .oled_mode(oled_mode), .ramp_sel(ramp_sel),
        .code_main(code_main), .code_sub(code_sub));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t exp_q[$];
    logic [7:0] rd_val;
    event rd_done;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // scoreboard monitor: compares each byte read from the bus
    initial begin
        exp_t e;
        forever begin
            @(rd_done);
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R6 got %0h expected none", rd_val);
            end else begin
                e = exp_q.pop_front();
                chk(e.req, {24'd0, rd_val}, {24'd0, e.val});
            end
        end
    end

    task automatic bus_start();
        sda_drv = 1'b1; #Q; scl_drv = 1'b1; #Q;
        sda_drv = 1'b0; #Q; scl_drv = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; #Q; scl_drv = 1'b1; #Q; sda_drv = 1'b1; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; #Q; scl_drv = 1'b1; #(2*Q); scl_drv = 1'b0; #Q;
        end
        sda_drv = 1'b1; #Q; scl_drv = 1'b1; #Q;
        ack = ~sda_line;
        #Q; scl_drv = 1'b0; #Q;
    endtask

    task automatic recv_byte(input logic give_ack);
        logic [7:0] b;
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; scl_drv = 1'b1; #Q; b[i] = sda_line; #Q; scl_drv = 1'b0;
        end
        rd_val = b;
        -> rd_done;
        #Q; sda_drv = ~give_ack; #Q; scl_drv = 1'b1; #(2*Q); scl_drv = 1'b0;
        sda_drv = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] p, input logic [7:0] d, input string req);
        logic a;
        bus_start();
        send_byte(8'h6C, a); chk({req, " R2 addr ack"}, a, 1);
        send_byte(p, a);     chk({req, " R2 ptr ack"}, a, 1);
        send_byte(d, a);     chk({req, " R2 data ack"}, a, 1);
        bus_stop();
        #(4*Q);
    endtask

    task automatic read_reg(input logic [7:0] p, input int n, input logic [7:0] e, input string req);
        logic a;
        exp_t x;
        for (int i = 0; i < n; i++) begin
            x.val = e; x.req = req;
            exp_q.push_back(x);
        end
        bus_start();
        send_byte(8'h6C, a); chk("R2 read addr ack", a, 1);
        send_byte(p, a);     chk("R2 read ptr ack", a, 1);
        bus_start();         // R7 repeated START into the read phase
        send_byte(8'h6D, a); chk("R1 read addr ack", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1);
        #Q;
        chk("R6 SDA released after NACK", sda_line, 1);
        bus_stop();
        #(4*Q);
    endtask

    task automatic sample_outs(output logic [15:0] v);
        @(negedge clk);
        v = {sink_main_on, sink_sub_on, unison, oled_mode, ramp_sel, code_main, code_sub};
    endtask

    // {main_on, sub_on, unison, oled, ramp[1:0], code_main[4:0], code_sub[4:0]}
    function automatic logic [15:0] pack(input logic m, s, u, o, input logic [1:0] r,
                                         input logic [4:0] cm, cs);
        return {m, s, u, o, r, cm, cs};
    endfunction

    initial begin
        #(800us);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic a;
        #(10*TCK);
        rst_n = 1'b1;
        #(10*TCK);

        // R11 reset state
        sample_outs(v);
        chk("R11 outputs after reset", v, 16'h0);
        chk("R11 sda_pull after reset", sda_pull, 0);
        chk("R11 pin_pull after reset", pin_pull, 0);

        // R4 reset readback
        read_reg(8'h10, 1, 8'hC0, "R4 gp reset");
        read_reg(8'hA0, 1, 8'hE0, "R4 bright A reset");
        read_reg(8'hB0, 1, 8'hE0, "R4 bright B reset");
        read_reg(8'h80, 1, 8'hF8, "R4 pin reg reset");

        // R3 R8 general register
        write_reg(8'h10, 8'h0B, "R3");
        sample_outs(v);
        chk("R8 gp=0x0B decode", v, pack(1, 1, 0, 0, 2'b01, 0, 0));
        read_reg(8'h10, 1, 8'hCB, "R4 gp readback");

        write_reg(8'hA0, 8'hFF, "R3");
        write_reg(8'hB0, 8'h05, "R3");
        sample_outs(v);
        chk("R3 brightness codes", v, pack(1, 1, 0, 0, 2'b01, 5'h1F, 5'h05));
        read_reg(8'hA0, 1, 8'hFF, "R4 bright A readback");
        read_reg(8'hB0, 1, 8'hE5, "R4 bright B readback");

        // R8 unison, enables, display mode
        write_reg(8'h10, 8'h05, "R8");
        sample_outs(v);
        chk("R8 unison on", v, pack(1, 1, 1, 0, 2'b00, 5'h1F, 5'h1F));
        write_reg(8'h10, 8'h04, "R8");
        sample_outs(v);
        chk("R8 unison, main off", v, pack(0, 0, 1, 0, 2'b00, 5'h1F, 5'h1F));
        write_reg(8'h10, 8'h22, "R8");
        sample_outs(v);
        chk("R8 oled with ENS", v, pack(0, 0, 0, 1, 2'b00, 5'h1F, 5'h05));
        write_reg(8'h10, 8'h39, "R8");
        sample_outs(v);
        chk("R8 oled with ENM ramp 11", v, pack(1, 0, 0, 1, 2'b11, 5'h1F, 5'h05));

        // R1 wrong address
        bus_start();
        send_byte(8'h6E, a); chk("R1 no ack other address", a, 0);
        send_byte(8'hA0, a); chk("R1 no ack after mismatch", a, 0);
        send_byte(8'h02, a); chk("R1 no ack data after mismatch", a, 0);
        bus_stop();
        #(4*Q);
        sample_outs(v);
        chk("R1 nothing written", v[9:5], 5'h1F);

        // R5 unmapped pointer
        write_reg(8'h11, 8'h55, "R5");
        read_reg(8'h11, 1, 8'hFF, "R5 unmapped read");
        read_reg(8'h10, 1, 8'hF9, "R5 gp untouched");

        // R6 multi-byte read with ACKs
        read_reg(8'hB0, 3, 8'hE5, "R6 repeated read");

        // R7 repeated START between pointer and data
        bus_start();
        send_byte(8'h6C, a); chk("R7 ack", a, 1);
        send_byte(8'hB0, a); chk("R7 ack", a, 1);
        bus_start();
        send_byte(8'h6C, a); chk("R7 ack after restart", a, 1);
        send_byte(8'hA0, a);
        send_byte(8'h07, a);
        bus_stop();
        #(4*Q);
        sample_outs(v);
        chk("R7 restart redirected write", v[9:0], {5'h07, 5'h05});
        // R7 STOP after pointer writes nothing
        bus_start();
        send_byte(8'h6C, a);
        send_byte(8'hA0, a);
        bus_stop();
        #(4*Q);
        sample_outs(v);
        chk("R7 stop after pointer", v[9:5], 5'h07);

        // R9 pin input mode
        write_reg(8'h80, 8'h01, "R9");
        pin_drv = 1'b0;
        #(4*Q);
        read_reg(8'h80, 1, 8'hF9, "R9 input low");
        sample_outs(v);
        chk("R9 input low no reset", v[9:5], 5'h07);
        pin_drv = 1'b1;
        #(4*Q);
        read_reg(8'h80, 1, 8'hFD, "R9 input high");
        // R9 output mode
        write_reg(8'h80, 8'h03, "R9");
        @(negedge clk);
        chk("R9 output drive low", pin_pull, 1);
        chk("R9 pin line low", pin_line, 0);
        sample_outs(v);
        chk("R9 output low no reset", v[9:5], 5'h07);
        read_reg(8'h80, 1, 8'hFB, "R9 output readback");
        write_reg(8'h80, 8'h07, "R9");
        @(negedge clk);
        chk("R9 output released", pin_pull, 0);
        read_reg(8'h80, 1, 8'hFF, "R9 released readback");
        write_reg(8'h80, 8'h00, "R9");

        // R10 pin reset hold
        pin_drv = 1'b0;
        #(10*TCK);
        sample_outs(v);
        chk("R10 outputs cleared", v, 16'h0);
        read_reg(8'h10, 1, 8'hC0, "R10 gp cleared");
        write_reg(8'hA0, 8'h1F, "R10");
        read_reg(8'hA0, 1, 8'hE0, "R10 write ignored");
        pin_drv = 1'b1;
        #(10*TCK);
        write_reg(8'hA0, 8'h1E, "R10");
        sample_outs(v);
        chk("R10 write after release", v[9:5], 5'h1E);

        #(10*TCK);
        chk("R6 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule